// File: doc/BRIEF.md
# Two-Wire Slave Configuration Register Bank

This block is the configuration front end of a programmable clock generator. It sits on a two-wire serial bus as a slave and holds the generator's settings: the prescaler exponent with its dither-depth select, a 10-bit frequency DAC code, a 5-bit range offset, and a small control register that holds the low three bits of the slave address and a commit-policy flag. A master addresses the block, writes a register pointer, then writes data bytes, or it issues a repeated START and reads bytes back. The DAC code spans two bytes and can be moved in one transaction, high byte first.

The bus lines arrive as plain inputs sampled by the block clock. They pass through a synchronizer, and START, STOP and SCL edges are detected from the synchronized copies. The only bus output is an SDA pull-down enable. A shadow copy of the settings stands in for the nonvolatile store. A commit copies live settings into the shadow at STOP and starts a busy timer of `NV_CYCLES` clocks. While that timer runs, the slave refuses every address byte.

Top module: `cfg_bank_slave`

## Requirements
- R1: After reset the live and shadow settings are: prescaler exponent 0, half-dither flag 0, DAC code 500, offset equal to `FACTORY_OS`, commit-policy flag 0 and address bits 000. A read of pointer 02h returns E0h. A two-byte read at 08h returns 7Dh then 00h.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 1011 followed by the three programmed address bits. Bit 0 of that byte is the direction, with 1 meaning read. Any other address byte gets no acknowledge.
- R3: A write transaction consists of the address byte, a pointer byte and then data. Data written at pointer 02h sets the prescaler exponent from bits 3..0 and the half-dither flag from bit 4. Bits 7..5 of that byte are discarded.
- R4: Pointer 08h holds DAC bits 9..2. Pointer 09h holds DAC bits 1..0 in its bits 7..6. After a byte moves at 08h, in either direction, the pointer steps to 09h. A two-byte write or read at 08h therefore moves the high byte first and the low byte second.
- R5: Read-back of unused bits is fixed. Pointer 02h returns 111 in bits 7..5. Pointer 0Eh returns 111 in bits 7..5 over the offset. Pointer 0Dh returns 1111 in bits 7..4 over {policy flag, address bits}. Pointer 09h returns 0 in bits 5..0.
- R6: Pointer 37h is read-only and returns `FACTORY_OS` in bits 4..0 with zeros above. Writes to 37h and to unmapped pointers are acknowledged but change nothing. Reads of unmapped pointers return 00h.
- R7: While the policy flag (bit 3 of register 0Dh) is 0, a data write to 02h, 08h, 09h or 0Eh causes the whole live set to be copied into the shadow at the next STOP.
- R8: While the policy flag is 1, those writes leave the shadow untouched and start no busy time. A write transaction whose pointer byte is 3Fh copies the whole live set into the shadow at the next STOP.
- R9: A data write to pointer 0Dh always copies the address register into the shadow at the next STOP. With the policy flag at 1, the other shadow fields stay as they were.
- R10: Every commit starts a busy window of `NV_CYCLES` clocks from STOP. During the window no address byte is acknowledged. After the window ends, address bytes are acknowledged again.
- R11: New address bits written to 0Dh take effect from the next transaction onward.
- R12: The SDA pull-down changes only while SCL is low, and it is released whenever the bus is idle after a STOP.
- R13: When the master does not acknowledge a read byte, the slave stops driving and waits for the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, sampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| div_sel_o | output | 4 | Live prescaler exponent |
| dither_half_o | output | 1 | Live half-depth dither select |
| dac_code_o | output | 10 | Live DAC code |
| offset_o | output | 5 | Live range offset |
| wr_ctl_o | output | 1 | Live commit-policy flag |
| dev_sel_o | output | 3 | Live low address bits |
| nv_prescale_o | output | 5 | Shadow {half-dither, exponent} |
| nv_dac_o | output | 10 | Shadow DAC code |
| nv_offset_o | output | 5 | Shadow offset |
| nv_addr_o | output | 4 | Shadow {policy flag, address bits} |

## Verification
The STOP that starts a commit and the address byte of the next transaction can overlap: the busy window is still open when that address byte completes. The bench provokes this by sending an address byte straight after a committing STOP and expects no acknowledge. After waiting out the window it expects the same byte to be acknowledged. It also checks the reverse case, where a write with the policy flag set is followed at once by an address byte. Because that write started no commit, the byte must be acknowledged.

// File: rtl/cbs_pkg.sv
// Shared constants and types for the configuration register bank.
// Assumes an 8-bit register pointer and a 10-bit DAC code.
package cbs_pkg;
    localparam logic [3:0] DEV_ID  = 4'b1011;
    localparam int         DAC_W   = 10;
    localparam int         OS_W    = 5;
    localparam int         DIV_W   = 4;
    localparam int         SEL_W   = 3;
    localparam logic [DAC_W-1:0] DAC_DEF = 10'd500;

    localparam logic [7:0] PT_PRESC = 8'h02;
    localparam logic [7:0] PT_DACH  = 8'h08;
    localparam logic [7:0] PT_DACL  = 8'h09;
    localparam logic [7:0] PT_ADDR  = 8'h0D;
    localparam logic [7:0] PT_OFFS  = 8'h0E;
    localparam logic [7:0] PT_RANGE = 8'h37;
    localparam logic [7:0] PT_NVCMD = 8'h3F;

    typedef struct packed {
        logic [DIV_W:0]   presc;   // {half dither, exponent}
        logic [DAC_W-1:0] dac;
        logic [OS_W-1:0]  offs;
        logic [SEL_W:0]   addr;    // {policy flag, address bits}
    } cfg_t;

    typedef enum logic [2:0] {L_IDLE, L_RX, L_AWAIT, L_ACK, L_TX, L_TACK} link_st_t;
    typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA} phase_t;
endpackage

// File: rtl/cbs_line_sync.sv
// Synchronizes SCL and SDA into the clock domain and flags SCL edges,
// START and STOP. Assumes the bus is slow against clk (several clocks per phase).
module cbs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p, scl_s;

    // Shift raw lines through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cbs_link.sv
// Byte-level slave engine: shifts bits in and out, decides acknowledges
// and emits pointer, data, read-advance and STOP strobes. Assumes the
// register side answers rd_data combinationally from its pointer.
module cbs_link
    import cbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic             nv_busy,
    input  logic [7:0]       rd_data,
    output logic             sda_pull,
    output logic [7:0]       byte_val,
    output logic             ptr_we,
    output logic             data_we,
    output logic             rd_adv,
    output logic             stop_evt
);
    link_st_t   st;
    phase_t     phase;
    logic [2:0] cnt;
    logic [7:0] shreg;
    logic       rw, ack_q, accept, byte_done;

    // Decode byte completion and the acknowledge decision.
    always_comb begin
        byte_val  = {shreg[6:0], sda_s};
        byte_done = (st == L_RX) && scl_rise && (cnt == 3'd7);
        accept    = (phase == PH_ADDR) ? ((byte_val[7:1] == {DEV_ID, dev_sel}) && !nv_busy) : 1'b1;
        ptr_we    = byte_done && (phase == PH_PTR);
        data_we   = byte_done && (phase == PH_DATA) && !rw;
        rd_adv    = (st == L_TACK) && scl_rise && !sda_s;
        stop_evt  = stop_det;
    end

    // Bus state machine: receive, acknowledge, transmit, master acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= L_IDLE;
            phase    <= PH_ADDR;
            cnt      <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            ack_q    <= 1'b0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            st       <= L_RX;
            phase    <= PH_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            st       <= L_IDLE;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                L_RX: if (scl_rise) begin
                    shreg <= byte_val;
                    cnt   <= cnt + 3'd1;
                    if (cnt == 3'd7) begin
                        st    <= L_AWAIT;
                        ack_q <= accept;
                        if (phase == PH_ADDR) rw <= sda_s;
                    end
                end
                L_AWAIT: if (scl_fall) begin
                    sda_pull <= ack_q;
                    st       <= ack_q ? L_ACK : L_IDLE;
                    if (phase == PH_ADDR) phase <= rw ? PH_DATA : PH_PTR;
                    else                  phase <= PH_DATA;
                end
                L_ACK: if (scl_fall) begin
                    cnt <= '0;
                    if (rw) begin
                        sda_pull <= ~rd_data[7];
                        shreg    <= {rd_data[6:0], 1'b0};
                        st       <= L_TX;
                    end else begin
                        sda_pull <= 1'b0;
                        st       <= L_RX;
                    end
                end
                L_TX: if (scl_fall) begin
                    if (cnt == 3'd7) begin
                        sda_pull <= 1'b0;
                        st       <= L_TACK;
                    end else begin
                        sda_pull <= ~shreg[7];
                        shreg    <= {shreg[6:0], 1'b0};
                        cnt      <= cnt + 3'd1;
                    end
                end
                L_TACK: if (scl_rise) st <= sda_s ? L_IDLE : L_ACK;
                default: st <= L_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cbs_regs.sv
// Live settings, shadow copy, register pointer and commit timer.
// Assumes strobes from the link are single-cycle and never coincide.
module cbs_regs
    import cbs_pkg::*;
#(
    parameter int              NV_CYCLES  = 1000000,
    parameter logic [OS_W-1:0] FACTORY_OS = 5'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_val,
    input  logic       ptr_we,
    input  logic       data_we,
    input  logic       rd_adv,
    input  logic       stop_evt,
    output logic [7:0] rd_data,
    output logic       nv_busy,
    output cfg_t       live,
    output cfg_t       nv
);
    localparam int TW = (NV_CYCLES < 2) ? 1 : $clog2(NV_CYCLES + 1);
    localparam cfg_t CFG_DEF = '{presc: '0, dac: DAC_DEF, offs: FACTORY_OS, addr: '0};

    logic [7:0]    ptr;
    logic [TW-1:0] tmr;
    logic          pend_all, pend_addr, wr_cfg;

    assign wr_cfg  = (ptr == PT_PRESC) || (ptr == PT_DACH) || (ptr == PT_DACL) || (ptr == PT_OFFS);
    assign nv_busy = (tmr != '0);

    // Pointer load and the 08h to 09h step after a DAC high byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ptr <= '0;
        else if (ptr_we)                                   ptr <= byte_val;
        else if ((data_we || rd_adv) && (ptr == PT_DACH))  ptr <= PT_DACL;
    end

    // Live register writes; read-only and unmapped pointers drop the data.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= CFG_DEF;
        else if (data_we) begin
            case (ptr)
                PT_PRESC: live.presc          <= byte_val[DIV_W:0];
                PT_DACH:  live.dac[DAC_W-1:2] <= byte_val;
                PT_DACL:  live.dac[1:0]       <= byte_val[7:6];
                PT_OFFS:  live.offs           <= byte_val[OS_W-1:0];
                PT_ADDR:  live.addr           <= byte_val[SEL_W:0];
                default:  ;
            endcase
        end
    end

    // Commit requests, shadow copy at STOP and the busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv        <= CFG_DEF;
            pend_all  <= 1'b0;
            pend_addr <= 1'b0;
            tmr       <= '0;
        end else if (stop_evt) begin
            if (pend_all)       nv      <= live;
            else if (pend_addr) nv.addr <= live.addr;
            if (pend_all || pend_addr) tmr <= TW'(NV_CYCLES);
            else if (tmr != '0)        tmr <= tmr - 1'b1;
            pend_all  <= 1'b0;
            pend_addr <= 1'b0;
        end else begin
            if (tmr != '0) tmr <= tmr - 1'b1;
            if (data_we && wr_cfg && !live.addr[SEL_W]) pend_all  <= 1'b1;
            if (data_we && (ptr == PT_ADDR))            pend_addr <= 1'b1;
            if (ptr_we && (byte_val == PT_NVCMD))       pend_all  <= 1'b1;
        end
    end

    // Read mux with fixed filler bits.
    always_comb begin
        case (ptr)
            PT_PRESC: rd_data = {3'b111, live.presc};
            PT_DACH:  rd_data = live.dac[DAC_W-1:2];
            PT_DACL:  rd_data = {live.dac[1:0], 6'b000000};
            PT_OFFS:  rd_data = {3'b111, live.offs};
            PT_ADDR:  rd_data = {4'b1111, live.addr};
            PT_RANGE: rd_data = {3'b000, FACTORY_OS};
            default:  rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfg_bank_slave.sv
// Top of the two-wire configuration register bank: line synchronizer,
// byte engine and register/shadow store. Assumes SCL phases last several clk.
module cfg_bank_slave
    import cbs_pkg::*;
#(
    parameter int              NV_CYCLES   = 1000000,
    parameter logic [OS_W-1:0] FACTORY_OS  = 5'h12,
    parameter int              SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic [DIV_W-1:0] div_sel_o,
    output logic             dither_half_o,
    output logic [DAC_W-1:0] dac_code_o,
    output logic [OS_W-1:0]  offset_o,
    output logic             wr_ctl_o,
    output logic [SEL_W-1:0] dev_sel_o,
    output logic [DIV_W:0]   nv_prescale_o,
    output logic [DAC_W-1:0] nv_dac_o,
    output logic [OS_W-1:0]  nv_offset_o,
    output logic [SEL_W:0]   nv_addr_o
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] byte_val, rd_data;
    logic       ptr_we, data_we, rd_adv, stop_evt, nv_busy;
    cfg_t       live, nv;

    cbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cbs_link u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_sel(live.addr[SEL_W-1:0]), .nv_busy(nv_busy), .rd_data(rd_data),
        .sda_pull(sda_pull_o), .byte_val(byte_val), .ptr_we(ptr_we),
        .data_we(data_we), .rd_adv(rd_adv), .stop_evt(stop_evt)
    );

    cbs_regs #(.NV_CYCLES(NV_CYCLES), .FACTORY_OS(FACTORY_OS)) u_regs (
        .clk(clk), .rst_n(rst_n), .byte_val(byte_val), .ptr_we(ptr_we),
        .data_we(data_we), .rd_adv(rd_adv), .stop_evt(stop_evt),
        .rd_data(rd_data), .nv_busy(nv_busy), .live(live), .nv(nv)
    );

    assign div_sel_o     = live.presc[DIV_W-1:0];
    assign dither_half_o = live.presc[DIV_W];
    assign dac_code_o    = live.dac;
    assign offset_o      = live.offs;
    assign wr_ctl_o      = live.addr[SEL_W];
    assign dev_sel_o     = live.addr[SEL_W-1:0];
    assign nv_prescale_o = nv.presc;
    assign nv_dac_o      = nv.dac;
    assign nv_offset_o   = nv.offs;
    assign nv_addr_o     = nv.addr;
endmodule

// File: rtl/cbs_checker.sv
// Temporal checks on the configuration register bank, bound to its top.
module cbs_checker
    import cbs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_pull_o,
    input logic             stop_evt,
    input logic             data_we,
    input logic             nv_busy,
    input logic [DAC_W-1:0] dac_code_o,
    input logic [DAC_W-1:0] nv_dac_o,
    input logic [SEL_W:0]   nv_addr_o
);
    // R1
    reset_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dac_code_o == DAC_DEF) && (nv_dac_o == DAC_DEF));

    // R12
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    // R4
    dac_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code_o) |-> $past(data_we));

    // R7
    nv_dac_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_dac_o) |-> $past(stop_evt));

    // R9
    nv_addr_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_addr_o) |-> $past(stop_evt));

    // R10
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nv_busy) |-> $stable(nv_addr_o) && $stable(nv_dac_o));
endmodule

bind cfg_bank_slave cbs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
    .stop_evt(stop_evt), .data_we(data_we), .nv_busy(nv_busy),
    .dac_code_o(dac_code_o), .nv_dac_o(nv_dac_o), .nv_addr_o(nv_addr_o)
);

// File: tb/cfg_bank_slave_test.sv
// Directed bench: one task per scenario, each checking its own results.
module cfg_bank_slave_test;
    localparam int NVC = 2000;
    localparam int Q   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull;
    logic [3:0] div_sel;
    logic       dither_half, wr_ctl;
    logic [9:0] dac_code, nv_dac;
    logic [4:0] offset, nv_presc, nv_offs;
    logic [2:0] dev_sel;
    logic [3:0] nv_addr;
    wire  sda_line = sda_m & ~sda_pull;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_bank_slave #(.NV_CYCLES(NVC), .FACTORY_OS(5'h12)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .div_sel_o(div_sel), .dither_half_o(dither_half),
        .dac_code_o(dac_code), .offset_o(offset), .wr_ctl_o(wr_ctl),
        .dev_sel_o(dev_sel), .nv_prescale_o(nv_presc), .nv_dac_o(nv_dac),
        .nv_offset_o(nv_offs), .nv_addr_o(nv_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(Q/2);
        end
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q/2);
        acked = (sda_line == 1'b0);
        wt(Q/2); scl_m = 1'b0; wt(Q/2);
    endtask

    task automatic rx_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl_m = 1'b1; wt(Q/2); b[i] = sda_line; wt(Q/2); scl_m = 1'b0; wt(Q/2);
        end
        sda_m = mack ? 1'b0 : 1'b1; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(Q/2);
        sda_m = 1'b1;
    endtask

    task automatic probe(input logic [7:0] b, output bit acked);
        bus_start(); tx_byte(b, acked); bus_stop();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] ptr, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, output bit ok);
        bit k;
        bus_start();
        tx_byte({4'b1011, a, 1'b0}, k); ok = k;
        if (ok) begin
            tx_byte(ptr, k); ok &= k;
            if (n > 0) begin tx_byte(d0, k); ok &= k; end
            if (n > 1) begin tx_byte(d1, k); ok &= k; end
        end
        bus_stop();
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] ptr, input int n,
                      output logic [7:0] r0, output logic [7:0] r1, output bit ok);
        bit k;
        r0 = 8'h00; r1 = 8'h00;
        bus_start();
        tx_byte({4'b1011, a, 1'b0}, k); ok = k;
        if (ok) begin
            tx_byte(ptr, k); ok &= k;
            bus_start();
            tx_byte({4'b1011, a, 1'b1}, k); ok &= k;
            if (ok) begin
                rx_byte(r0, n > 1);
                if (n > 1) rx_byte(r1, 1'b0);
            end
        end
        bus_stop();
    endtask

    task automatic wait_nv();
        wt(NVC + 100);
    endtask

    task automatic t_reset();
        logic [7:0] r0, r1; bit ok;
        chk("R1 div_sel", div_sel, 0);
        chk("R1 dither", dither_half, 0);
        chk("R1 dac", dac_code, 500);
        chk("R1 offset", offset, 5'h12);
        chk("R1 nv_dac", nv_dac, 500);
        chk("R1 nv_addr", nv_addr, 0);
        chk("R12 idle pull", sda_pull, 0);
        rd(3'd0, 8'h02, 1, r0, r1, ok);
        chk("R1 ack", ok, 1);
        chk("R1 R5 read 02", r0, 8'hE0);
        rd(3'd0, 8'h08, 2, r0, r1, ok);
        chk("R1 R4 read 08 hi", r0, 8'h7D);
        chk("R1 R4 read 09 lo", r1, 8'h00);
    endtask

    task automatic t_match();
        bit k;
        probe(8'hA0, k);  chk("R2 wrong id", k, 0);
        probe(8'hB2, k);  chk("R2 wrong sel", k, 0);
        chk("R12 pull after nack", sda_pull, 0);
        probe(8'hB0, k);  chk("R2 match", k, 1);
    endtask

    task automatic t_prescale();
        logic [7:0] r0, r1; bit ok, k;
        wr(3'd0, 8'h02, 1, 8'hFB, 8'h00, ok);
        chk("R3 ack", ok, 1);
        chk("R3 div_sel", div_sel, 4'hB);
        chk("R3 dither", dither_half, 1);
        chk("R7 nv_presc", nv_presc, 5'h1B);
        probe(8'hB0, k); chk("R10 busy nack", k, 0);
        wait_nv();
        probe(8'hB0, k); chk("R10 after window", k, 1);
        rd(3'd0, 8'h02, 1, r0, r1, ok);
        chk("R5 read 02", r0, 8'hFB);
    endtask

    task automatic t_dac();
        logic [7:0] r0, r1; bit ok;
        wr(3'd0, 8'h08, 2, 8'hA3, 8'hC0, ok);
        chk("R4 ack", ok, 1);
        chk("R4 dac", dac_code, 655);
        chk("R7 nv_dac", nv_dac, 655);
        wait_nv();
        rd(3'd0, 8'h08, 2, r0, r1, ok);
        chk("R4 read hi", r0, 8'hA3);
        chk("R4 read lo", r1, 8'hC0);
        wr(3'd0, 8'h09, 1, 8'h7F, 8'h00, ok);
        chk("R4 low only", dac_code, 653);
        wait_nv();
        rd(3'd0, 8'h09, 1, r0, r1, ok);
        chk("R5 read 09", r0, 8'h40);
    endtask

    task automatic t_range();
        logic [7:0] r0, r1; bit ok, k;
        wr(3'd0, 8'h37, 1, 8'h00, 8'h00, ok);
        chk("R6 write 37 ack", ok, 1);
        wr(3'd0, 8'h20, 1, 8'h55, 8'h00, ok);
        chk("R6 write 20 ack", ok, 1);
        probe(8'hB0, k); chk("R6 no commit", k, 1);
        chk("R6 offset kept", offset, 5'h12);
        rd(3'd0, 8'h37, 1, r0, r1, ok);
        chk("R6 read 37", r0, 8'h12);
        rd(3'd0, 8'h20, 1, r0, r1, ok);
        chk("R6 read 20", r0, 8'h00);
        rd(3'd0, 8'h0E, 1, r0, r1, ok);
        chk("R5 read 0E", r0, 8'hF2);
        wr(3'd0, 8'h0E, 1, 8'h10, 8'h00, ok);
        chk("R3 offset", offset, 5'h10);
        chk("R7 nv_offs", nv_offs, 5'h10);
        wait_nv();
        rd(3'd0, 8'h0E, 1, r0, r1, ok);
        chk("R5 read 0E new", r0, 8'hF0);
    endtask

    task automatic t_policy();
        bit ok, k;
        wr(3'd0, 8'h0D, 1, 8'h08, 8'h00, ok);
        chk("R9 wr_ctl", wr_ctl, 1);
        chk("R9 nv_addr", nv_addr, 4'h8);
        wait_nv();
        wr(3'd0, 8'h02, 1, 8'h05, 8'h00, ok);
        chk("R8 div_sel", div_sel, 4'h5);
        chk("R8 nv held", nv_presc, 5'h1B);
        probe(8'hB0, k); chk("R8 no busy", k, 1);
        bus_start(); tx_byte(8'hB0, k); tx_byte(8'h3F, k); bus_stop();
        chk("R8 cmd commit", nv_presc, 5'h05);
        probe(8'hB0, k); chk("R10 cmd busy", k, 0);
        wait_nv();
    endtask

    task automatic t_newaddr();
        logic [7:0] r0, r1; bit ok, k;
        wr(3'd0, 8'h0D, 1, 8'h0D, 8'h00, ok);
        chk("R11 write ack", ok, 1);
        chk("R9 nv_addr WC=1", nv_addr, 4'hD);
        chk("R9 nv_presc kept", nv_presc, 5'h05);
        wait_nv();
        probe(8'hB0, k); chk("R11 old addr", k, 0);
        probe(8'hBA, k); chk("R11 new addr", k, 1);
        rd(3'd5, 8'h0D, 1, r0, r1, ok);
        chk("R5 read 0D", r0, 8'hFD);
    endtask

    task automatic t_mnack();
        logic [7:0] r0, r1; bit ok;
        rd(3'd5, 8'h08, 1, r0, r1, ok);
        chk("R13 byte", r0, 8'hA3);
        chk("R13 released", sda_pull, 0);
        rd(3'd5, 8'h09, 1, r0, r1, ok);
        chk("R13 next ok", ok, 1);
        chk("R13 next byte", r0, 8'h40);
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_match();
        t_prescale();
        t_dac();
        t_range();
        t_policy();
        t_newaddr();
        t_mnack();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule